// File: doc/BRIEF.md
# Eight-Lane Montgomery Modular Multiplier

This block performs SIMD modular arithmetic on a wide word split into independent lanes (eight lanes of 32 bits by default). In multiply mode every lane forms the Montgomery product of its two operands: the product a*b scaled by 2^-32 modulo a shared odd modulus q. It uses only multiplies, adds and shifts, with no division. The modulus and the Montgomery constant mu = (-q)^-1 mod 2^32 arrive together on one 64-bit modulus input.

The last conditional subtraction of the Montgomery algorithm is left out to save area, so a multiply result lies in [0, 2q). A second operation, a lane-wise modular add, brings values back to [0, q) when it is run with a zero second operand. Because the result is only partly reduced, multiplies can feed one another without a reduction pass between them, as long as q < 2^30.

Both operations go through the same three-stage pipeline. A new operation may start on every cycle. Each start produces one single-cycle valid pulse that updates all lanes at once.

Top module: `vmm_top`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and res_o is all zeros.
- R2: When start_i is sampled high at a rising edge, valid_o is high for exactly one cycle after the third rising edge from that one. Starts on consecutive cycles each produce their own result on consecutive cycles.
- R3: Lane k occupies bits [32k+31:32k] of opa_i, opb_i and res_o. A lane's result depends only on that lane's operands and the shared modulus.
- R4: The modulus q is mod_i[31:0] and mu is mod_i[63:32]. Both are sampled with start_i, so changing mod_i afterwards does not affect that operation.
- R5: With op_i = 0 (multiply), each lane result r satisfies r*2^32 ≡ a*b (mod q), computed as t = a*b mod 2^32, m = t*mu mod 2^32, r = (a*b + m*q) >> 32.
- R6: With q odd, q < 2^30 and both lane operands below 2q, a multiply result is below 2q. No final subtraction is made, so a result may be q or more.
- R7: With op_i = 1 (modular add), each lane result is a+b, minus q when a+b ≥ q. This equals (a+b) mod q whenever a+b < 2q.
- R8: A modular add with a zero second operand maps any lane value in [0, 2q) to its residue in [0, q).
- R9: Between valid pulses, res_o holds its last value whatever the operand and modulus inputs do.
- R10: A multiply result used unreduced as an operand of a further multiply gives a correct result that is still below 2q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation on the inputs present this cycle |
| op_i | input | 1 | Operation select: 0 Montgomery multiply, 1 modular add |
| mod_i | input | 64 | q in [31:0], mu in [63:32] |
| opa_i | input | 256 | First operand, eight 32-bit lanes |
| opb_i | input | 256 | Second operand, eight 32-bit lanes |
| res_o | output | 256 | Lane results, held between valid pulses |
| valid_o | output | 1 | One-cycle pulse when res_o is updated |

## Verification
The bench builds the block with its default eight 32-bit lanes, so every lane is checked on each operation. It compares each lane with a model that works modulo q and accepts the reduced value or that value plus q. The moduli range from tiny primes up to 2^30 - 35. At the top of that range, operands near 2q push unreduced products past q, which shows that the final subtraction really is absent. Operands near 2q also drive chained products toward the [0, 2q) bound.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_ADD = 1'b1
  } vmm_op_e;

  // stage 1: product, stage 2: m, stage 3: fold high half
  localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/vmm_stage_ctrl.sv
module vmm_stage_ctrl #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [DEPTH-1:0] en_o,
  output logic             valid_o
);
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[DEPTH-2:0], start_i};
  end

  assign en_o[0] = start_i;
  for (genvar i = 1; i < DEPTH; i++) begin : g_en
    assign en_o[i] = vld_q[i-1];
  end

  assign valid_o = vld_q[DEPTH-1];
endmodule

// File: rtl/vmm_addm.sv
module vmm_addm #(
  parameter int unsigned EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [EW-1:0] q_i,
  output logic [EW-1:0] sum_o
);
  logic [EW:0]   sum_w;
  logic [EW-1:0] diff_w;

  assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
  // low bits of sum - q; carry handled by the compare
  assign diff_w = sum_w[EW-1:0] - q_i;
  assign sum_o  = (sum_w >= {1'b0, q_i}) ? diff_w : sum_w[EW-1:0];
endmodule

// File: rtl/vmm_lane.sv
module vmm_lane import vmm_pkg::*; #(
  parameter int unsigned EW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    en_i,
  input  vmm_op_e       op_i,
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [EW-1:0] q_i,
  input  logic [EW-1:0] mu_i,
  output logic [EW-1:0] res_o
);
  localparam int unsigned DW = 2 * EW;

  logic [EW-1:0] add_w;

  vmm_addm #(.EW(EW)) u_addm (
    .a_i  (a_i),
    .b_i  (b_i),
    .q_i  (q_i),
    .sum_o(add_w)
  );

  // stage 1: full product
  logic [DW-1:0] prod_q;
  logic [EW-1:0] q1_q, mu1_q, add1_q;
  vmm_op_e       op1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      q1_q   <= '0;
      mu1_q  <= '0;
      add1_q <= '0;
      op1_q  <= OP_MUL;
    end else if (en_i[0]) begin
      prod_q <= DW'(a_i) * DW'(b_i);
      q1_q   <= q_i;
      mu1_q  <= mu_i;
      add1_q <= add_w;
      op1_q  <= op_i;
    end
  end

  // stage 2: m = t * mu mod 2^EW
  logic [EW-1:0] m_w;
  logic [EW-1:0] m_q, ph_q, q2_q, add2_q;
  vmm_op_e       op2_q;

  assign m_w = prod_q[EW-1:0] * mu1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= '0;
      ph_q   <= '0;
      q2_q   <= '0;
      add2_q <= '0;
      op2_q  <= OP_MUL;
    end else if (en_i[1]) begin
      m_q    <= m_w;
      ph_q   <= prod_q[DW-1:EW];
      q2_q   <= q1_q;
      add2_q <= add1_q;
      op2_q  <= op1_q;
    end
  end

  // stage 3: high half of a*b + m*q; low halves cancel, only the carry survives
  logic [DW-1:0] mq_w;
  logic          carry_w;
  logic [EW-1:0] mont_w;
  logic [EW-1:0] res_q;

  assign mq_w    = DW'(m_q) * DW'(q2_q);
  assign carry_w = |mq_w[EW-1:0];
  assign mont_w  = ph_q + mq_w[DW-1:EW] + EW'(carry_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (en_i[2])   res_q <= (op2_q == OP_ADD) ? add2_q : mont_w;
  end

  assign res_o = res_q;
endmodule

// File: rtl/vmm_top.sv
module vmm_top import vmm_pkg::*; #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  op_i,
  input  logic [2*EW-1:0]       mod_i,
  input  logic [LANES*EW-1:0]   opa_i,
  input  logic [LANES*EW-1:0]   opb_i,
  output logic [LANES*EW-1:0]   res_o,
  output logic                  valid_o
);
  logic [PIPE_DEPTH-1:0] en_w;
  logic [EW-1:0]         q_w, mu_w;
  vmm_op_e               op_w;

  assign q_w  = mod_i[EW-1:0];
  assign mu_w = mod_i[2*EW-1:EW];
  assign op_w = vmm_op_e'(op_i);

  vmm_stage_ctrl #(.DEPTH(PIPE_DEPTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .en_o   (en_w),
    .valid_o(valid_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vmm_lane #(.EW(EW)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_w),
      .op_i  (op_w),
      .a_i   (opa_i[k*EW +: EW]),
      .b_i   (opb_i[k*EW +: EW]),
      .q_i   (q_w),
      .mu_i  (mu_w),
      .res_o (res_o[k*EW +: EW])
    );
  end
endmodule

// File: rtl/vmm_checker.sv
module vmm_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                op_i,
  input logic [EW-1:0]       q_i,
  input logic [LANES*EW-1:0] opa_i,
  input logic [LANES*EW-1:0] opb_i,
  input logic [LANES*EW-1:0] res_o,
  input logic                valid_o
);
  logic [1:0] seen_q;
  logic       settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               seen_q <= '0;
    else if (seen_q != 2'd3)   seen_q <= seen_q + 2'd1;
  end
  assign settled = (seen_q == 2'd3);

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> (valid_o == $past(start_i, 3)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0 && !valid_o) |-> $stable(res_o));

  logic [EW:0] q2_w;
  logic        q_small_w;
  assign q2_w      = {q_i, 1'b0};
  assign q_small_w = q_i[0] && ((q_i >> (EW - 2)) == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    logic [EW:0] a_x, b_x;
    logic        mul_ok, add_ok;
    assign a_x    = {1'b0, opa_i[k*EW +: EW]};
    assign b_x    = {1'b0, opb_i[k*EW +: EW]};
    // op_i: 0 multiply, 1 add
    assign mul_ok = start_i && !op_i && q_small_w && (a_x < q2_w) && (b_x < q2_w);
    assign add_ok = start_i && op_i && ((a_x + b_x) < q2_w);

    assert_mul_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && valid_o && $past(mul_ok, 3)) |->
        ({1'b0, res_o[k*EW +: EW]} < $past(q2_w, 3)));

    assert_add_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled && valid_o && $past(add_ok, 3)) |->
        (res_o[k*EW +: EW] < $past(q_i, 3)));
  end
endmodule

bind vmm_top vmm_checker #(.LANES(LANES), .EW(EW)) u_vmm_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_i   (op_i),
  .q_i    (mod_i[EW-1:0]),
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .res_o  (res_o),
  .valid_o(valid_o)
);

// File: tb/vmm_top_test.sv
module vmm_top_test;
  localparam int LANES = 8;
  localparam int EW    = 32;
  localparam int W     = LANES * EW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op = 1'b0;
  logic [63:0]  mod_w = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] res;
  logic         valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vmm_top #(.LANES(LANES), .EW(EW)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .op_i   (op),
    .mod_i  (mod_w),
    .opa_i  (opa),
    .opb_i  (opb),
    .res_o  (res),
    .valid_o(valid)
  );

  // stimulus table: op 0 multiply (operands < 2q), op 1 add (operands < q)
  localparam int NV = 6;
  localparam logic [31:0] T_Q  [NV] = '{32'd8380417, 32'd3329, 32'h3FFFFFDD,
                                        32'd12289, 32'd97, 32'h3FFFFFDD};
  localparam bit          T_OP [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] T_SA [NV] = '{32'h1234567, 32'h0BADF00D, 32'h7FFFFF01,
                                        32'h55AA55AA, 32'h13579BDF, 32'h7FFFFFFF};
  localparam logic [31:0] T_SB [NV] = '{32'h89ABCDE, 32'h00C0FFEE, 32'h3C3C3C3C,
                                        32'h2468ACE0, 32'h0F0F0F0F, 32'h7FFFFFBB};

  function automatic logic [31:0] calc_mu(input logic [31:0] q);
    logic [31:0] inv;
    inv = q;
    for (int i = 0; i < 5; i++) inv = inv * (32'd2 - q * inv);
    return 32'd0 - inv;
  endfunction

  function automatic logic [31:0] mont_ref(input logic [31:0] a, b, q);
    logic [63:0] x;
    x = ({32'd0, a} * {32'd0, b}) % {32'd0, q};
    for (int i = 0; i < 32; i++) x = x[0] ? ((x + {32'd0, q}) >> 1) : (x >> 1);
    return x[31:0];
  endfunction

  function automatic logic [31:0] lane_val(input logic [31:0] seed, input int k,
                                           input logic [63:0] lim);
    logic [63:0] v;
    v = {32'd0, seed} * 64'(k + 3) + 64'(k) * 64'h9E3779B9;
    v = v % lim;
    return v[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_mul_lane(input string req, input int k, input logic [31:0] r,
                                input logic [31:0] a, b, q);
    logic [31:0] e;
    e = mont_ref(a, b, q);
    check((r == e || r == e + q) && ({1'b0, r} < {q, 1'b0}), req,
          $sformatf("lane %0d mul", k), W'(r), W'(e));
  endtask

  task automatic run_op(input logic o, input logic [W-1:0] a, b,
                        input logic [31:0] q, output logic [W-1:0] r);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b; mod_w = {calc_mu(q), q};
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(valid == 1'b1, "R2", "valid after three edges", W'(valid), W'(1));
    r = res;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, r, r2, r3;
    logic [31:0]  q;
    int           big;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1", "valid in reset", W'(valid), W'(0));
    check(res == '0, "R1", "res in reset", res, '0);
    rst_n = 1'b1;

    // R2 latency and single-cycle pulse
    @(negedge clk);
    q = 32'd3329;
    start = 1'b1; op = 1'b1; mod_w = {calc_mu(q), q};
    opa = '0; opb = '0;
    for (int k = 0; k < LANES; k++) begin
      opa[k*EW +: EW] = 32'(k * 100);
      opb[k*EW +: EW] = 32'd5;
    end
    @(negedge clk); start = 1'b0;
    check(valid == 1'b0, "R2", "valid one cycle after", W'(valid), W'(0));
    @(negedge clk);
    check(valid == 1'b0, "R2", "valid two cycles after", W'(valid), W'(0));
    @(negedge clk);
    check(valid == 1'b1, "R2", "valid three cycles after", W'(valid), W'(1));
    check(res[3*EW +: EW] == 32'd305, "R7", "add small", W'(res[3*EW +: EW]), W'(305));
    @(negedge clk);
    check(valid == 1'b0, "R2", "pulse ends", W'(valid), W'(0));

    // R2 back-to-back, R4 modulus sampled with start
    @(negedge clk);
    start = 1'b1; op = 1'b1; q = 32'd97; mod_w = {calc_mu(q), q};
    opa = {LANES{32'd90}}; opb = {LANES{32'd10}};
    @(negedge clk);
    q = 32'd1000; mod_w = {calc_mu(q), q};
    opa = {LANES{32'd600}}; opb = {LANES{32'd500}};
    @(negedge clk); start = 1'b0;
    mod_w = {calc_mu(32'd7), 32'd7};
    @(negedge clk);
    check(valid && res[EW-1:0] == 32'd3, "R4", "first of pair, q sampled at start",
          W'(res[EW-1:0]), W'(3));
    @(negedge clk);
    check(valid && res[EW-1:0] == 32'd100, "R2", "second of pair",
          W'(res[EW-1:0]), W'(100));
    @(negedge clk);
    check(valid == 1'b0, "R2", "pair pulses end", W'(valid), W'(0));

    // table walk: R5 multiply, R7 add, R3 per-lane slices
    for (int v = 0; v < NV; v++) begin
      q = T_Q[v];
      for (int k = 0; k < LANES; k++) begin
        a[k*EW +: EW] = lane_val(T_SA[v], k, T_OP[v] ? {32'd0, q} : {31'd0, q, 1'b0});
        b[k*EW +: EW] = lane_val(T_SB[v], k, T_OP[v] ? {32'd0, q} : {31'd0, q, 1'b0});
      end
      run_op(T_OP[v], a, b, q, r);
      for (int k = 0; k < LANES; k++) begin
        if (!T_OP[v]) begin
          check_mul_lane("R5", k, r[k*EW +: EW], a[k*EW +: EW], b[k*EW +: EW], q);
        end else begin
          logic [32:0] s;
          s = {1'b0, a[k*EW +: EW]} + {1'b0, b[k*EW +: EW]};
          if (s >= {1'b0, q}) s = s - {1'b0, q};
          check(r[k*EW +: EW] == s[31:0], "R7", $sformatf("lane %0d add R3", k),
                W'(r[k*EW +: EW]), W'(s[31:0]));
        end
      end
    end

    // R3 lane isolation: change only lane 5
    q = 32'd8380417;
    for (int k = 0; k < LANES; k++) begin
      a[k*EW +: EW] = 32'(1000 + k);
      b[k*EW +: EW] = 32'(77 * k + 1);
    end
    run_op(1'b0, a, b, q, r);
    a[5*EW +: EW] = 32'd4000000;
    run_op(1'b0, a, b, q, r2);
    for (int k = 0; k < LANES; k++) begin
      if (k != 5)
        check(r2[k*EW +: EW] == r[k*EW +: EW], "R3", $sformatf("lane %0d untouched", k),
              W'(r2[k*EW +: EW]), W'(r[k*EW +: EW]));
    end
    check_mul_lane("R3", 5, r2[5*EW +: EW], 32'd4000000, b[5*EW +: EW], q);

    // R6 near-2q operands at q = 2^30-35: range held, no final subtraction
    q = 32'h3FFFFFDD;
    for (int k = 0; k < LANES; k++) begin
      a[k*EW +: EW] = {q[30:0], 1'b0} - 32'(1 + 3 * k);
      b[k*EW +: EW] = {q[30:0], 1'b0} - 32'(1 + k);
    end
    run_op(1'b0, a, b, q, r);
    big = 0;
    for (int k = 0; k < LANES; k++) begin
      check_mul_lane("R6", k, r[k*EW +: EW], a[k*EW +: EW], b[k*EW +: EW], q);
      if (r[k*EW +: EW] >= q) big++;
    end
    check(big > 0, "R6", "some lane left unreduced", W'(big), W'(1));

    // R8 fold [0,2q) to [0,q) with zero operand
    for (int k = 0; k < LANES; k++)
      a[k*EW +: EW] = (k % 2 == 1) ? q + 32'(k * 12345) : 32'(k * 54321);
    run_op(1'b1, a, '0, q, r3);
    for (int k = 0; k < LANES; k++)
      check(r3[k*EW +: EW] == (a[k*EW +: EW] % q), "R8", $sformatf("lane %0d fold", k),
            W'(r3[k*EW +: EW]), W'(a[k*EW +: EW] % q));

    // R9 hold between pulses
    @(negedge clk);
    opa = ~opa; opb = ~opb; mod_w = ~mod_w; op = ~op;
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R9", "no pulse without start", W'(valid), W'(0));
    check(res == r3, "R9", "result held", res, r3);

    // R10 chain unreduced products, then fold
    q = 32'h3FFFFFDD;
    for (int k = 0; k < LANES; k++) begin
      a[k*EW +: EW] = lane_val(32'h6D2B79F5, k, {31'd0, q, 1'b0});
      b[k*EW +: EW] = lane_val(32'h2545F491, k, {31'd0, q, 1'b0});
    end
    run_op(1'b0, a, b, q, r);
    run_op(1'b0, r, r, q, r2);
    for (int k = 0; k < LANES; k++)
      check_mul_lane("R10", k, r2[k*EW +: EW], r[k*EW +: EW], r[k*EW +: EW], q);
    run_op(1'b1, r2, '0, q, r3);
    for (int k = 0; k < LANES; k++)
      check(r3[k*EW +: EW] == mont_ref(r[k*EW +: EW], r[k*EW +: EW], q), "R10",
            $sformatf("lane %0d chained fold", k), W'(r3[k*EW +: EW]),
            W'(mont_ref(r[k*EW +: EW], r[k*EW +: EW], q)));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule